// File: doc/BRIEF.md
# Multi-Domain Power Mode Sequencer

This block steers the low-power behaviour of a microcontroller built from one always-on region and two switchable regions, named isolation-0 and isolation-1. Software or a system controller posts a target mode through a one-cycle request strobe. A wake strobe brings the chip back from any low-power mode. For each switchable region the block drives a power-switch enable, a boundary mask for every signal that leaves the region, a region reset and a region clock enable. It also drives the CPU clock enable. External switch acknowledge inputs report when each region's supply has actually come up or gone down.

Each switchable region has its own sequencer. That sequencer moves the region between three settled states: clocked, powered with its clock stopped, and unpowered. It takes these steps in a fixed order, so a region never presents unmasked outputs while its supply is absent or changing. The mode controller above the sequencers translates the target mode into one settled state per region and waits until both regions report arrival. Only then does it publish the new mode code. It holds any request or wake that arrives while a change is in progress, and applies it once the change has finished.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode code is 0 (Run), `busy` is 0, both switch enables, both region resets (active low, so value 1), both clock enables and `cpu_clk_en` are 1, and both masks are 0.
- R2: Mode codes are 0 Run, 1 Halt, 2 Stop, 3 DeepStop, 4 Run with isolation-1 off, 5 Halt with isolation-1 off, 6 Stop with isolation-1 off. Once a change has completed, isolation-0 is clocked in modes 0,1,4,5, stopped-but-powered in 2 and 6, and unpowered in 3. Isolation-1 is clocked in 0 and 1, stopped-but-powered in 2, and unpowered in 3 to 6. A clocked region shows switch 1, mask 0, reset 1, clock 1. A stopped region shows switch 1, mask 0, reset 1, clock 0. An unpowered region shows switch 0, mask 1, reset 0, clock 0.
- R3: A request with code 7, or a request equal to the current mode while no change is in progress, starts no change: `busy` stays 0 and the outputs do not move.
- R4: When a region is powered down, its clock stops first. The mask rises on a later cycle, the reset is asserted on a cycle after that, and the switch enable falls last. Each step is at least one cycle after the step before it.
- R5: When a region is powered up, the switch enable rises first. The reset is released only while the acknowledge is high. The mask clears exactly SETTLE+2 cycles after the acknowledge is first seen high, where SETTLE is that region's settle parameter. The clock is enabled only while the mask is clear and the reset is released.
- R6: Whenever a region's switch enable is 0, its mask is 1, its reset is asserted and its clock is off.
- R7: `cpu_clk_en` is 1 only while no change is in progress and the mode is 0 or 4, and only while isolation-0 is clocked.
- R8: A wake strobe in mode 1, 2, 3, 5 or 6 returns the block to mode 0 with both regions clocked. A wake in mode 0 or 4 is ignored.
- R9: If a wake and a request arrive in the same cycle in a low-power mode, the wake wins and the block goes to mode 0.
- R10: A request that arrives while a change is in progress is held and applied right after that change completes. If several requests arrive, only the last one is kept.
- R11: A wake that arrives while a change is in progress is held. It is applied after completion if the reached mode is low-power, and dropped otherwise.
- R12: `busy` is 1 while a change is in progress. The mode code changes only in the cycle in which `busy` falls, and it then shows the mode just reached.
- R13: The regions are sequenced independently: going from mode 0 to mode 4 powers isolation-1 down without ever stopping the isolation-0 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code |
| wake | input | 1 | One-cycle wake strobe |
| sw_ack | input | 2 | Per-region switch acknowledge, 1 = supply present |
| sw_en | output | 2 | Per-region power-switch enable |
| iso_mask | output | 2 | Per-region boundary mask, 1 = masked |
| dom_rst_n | output | 2 | Per-region reset, active low |
| dom_clk_en | output | 2 | Per-region clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| mode_stat | output | 3 | Current mode code |
| busy | output | 1 | Mode change in progress |

## Verification
The central collision is a wake strobe landing in the same cycle as a mode request. A related case is either of them landing while a power-down sequence is still waiting on a switch acknowledge. The bench drives the wake and the request in the same cycle from a low-power mode and expects Run. It then fires requests and wakes in the middle of a DeepStop entry and expects two published results in turn: DeepStop first, then the held request or Run. Every mode-to-mode pair is swept, and a per-cycle monitor judges the step ordering and the exact settle delay on each power-up.

// File: rtl/pwr_mode_pkg.sv
// Shared types and mode decoding for the power mode sequencer.
// Assumes exactly two switchable regions; index 0 is isolation-0.
package pwr_mode_pkg;

    localparam int NDOM = 2;
    localparam int MW   = 3;

    localparam logic [MW-1:0] PM_RUN     = 3'd0;
    localparam logic [MW-1:0] PM_HALT    = 3'd1;
    localparam logic [MW-1:0] PM_STOP    = 3'd2;
    localparam logic [MW-1:0] PM_DEEP    = 3'd3;
    localparam logic [MW-1:0] PM_RUN_X1  = 3'd4;
    localparam logic [MW-1:0] PM_HALT_X1 = 3'd5;
    localparam logic [MW-1:0] PM_STOP_X1 = 3'd6;

    // Settled state a region is asked to reach.
    typedef enum logic [1:0] {
        DT_ON    = 2'd0,
        DT_GATED = 2'd1,
        DT_OFF   = 2'd2
    } dtgt_t;

    // A code names a mode unless it is the one spare value.
    function automatic logic mode_legal(input logic [MW-1:0] m);
        return m != 3'd7;
    endfunction

    // Modes in which the CPU clock may run.
    function automatic logic cpu_runs(input logic [MW-1:0] m);
        return (m == PM_RUN) || (m == PM_RUN_X1);
    endfunction

    // Modes from which a wake returns to Run.
    function automatic logic is_low_power(input logic [MW-1:0] m);
        return mode_legal(m) && !cpu_runs(m);
    endfunction

    // Per-region settled state demanded by a mode.
    function automatic dtgt_t dom_target(input logic [MW-1:0] m, input int unsigned idx);
        dtgt_t t;
        if (idx == 0) begin
            case (m)
                PM_STOP, PM_STOP_X1: t = DT_GATED;
                PM_DEEP:             t = DT_OFF;
                default:             t = DT_ON;
            endcase
        end else begin
            case (m)
                PM_RUN, PM_HALT: t = DT_ON;
                PM_STOP:         t = DT_GATED;
                default:         t = DT_OFF;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/pwr_dom_seq.sv
// Sequencer for one switchable region.
// Moves the region between clocked, stopped and unpowered states in a
// fixed order: clock, mask, reset, switch on the way down, reversed on the
// way up, with SETTLE cycles of settle time after the switch acknowledge.
// Assumes the target is held stable until at_tgt is seen.
module pwr_dom_seq
    import pwr_mode_pkg::*;
#(
    parameter int SETTLE = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  dtgt_t tgt,
    input  logic  sw_ack,
    output logic  sw_en,
    output logic  iso_mask,
    output logic  dom_rst_n,
    output logic  clk_en,
    output logic  at_tgt
);

    localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);
    localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE - 1);

    typedef enum logic [3:0] {
        DS_ON        = 4'd0,
        DS_GATED     = 4'd1,
        DS_DN_MASK   = 4'd2,
        DS_DN_RST    = 4'd3,
        DS_DN_SW     = 4'd4,
        DS_OFF       = 4'd5,
        DS_UP_SW     = 4'd6,
        DS_UP_SETTLE = 4'd7,
        DS_UP_RST    = 4'd8
    } dstate_t;

    dstate_t        st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // Next-state selection for the region step sequence.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            DS_ON:        if (tgt != DT_ON) st_d = DS_GATED;
            DS_GATED: begin
                if (tgt == DT_ON)       st_d = DS_ON;
                else if (tgt == DT_OFF) st_d = DS_DN_MASK;
            end
            DS_DN_MASK:   st_d = DS_DN_RST;
            DS_DN_RST:    st_d = DS_DN_SW;
            DS_DN_SW:     if (!sw_ack) st_d = DS_OFF;
            DS_OFF:       if (tgt != DT_OFF) st_d = DS_UP_SW;
            DS_UP_SW: begin
                if (sw_ack) begin
                    st_d  = DS_UP_SETTLE;
                    cnt_d = CNT_LOAD;
                end
            end
            DS_UP_SETTLE: begin
                if (cnt_q == '0) st_d = DS_UP_RST;
                else             cnt_d = cnt_q - 1'b1;
            end
            DS_UP_RST:    st_d = DS_GATED;
            default:      st_d = DS_OFF;
        endcase
    end

    // State and settle counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DS_ON;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output decode per step.
    always_comb begin
        sw_en     = 1'b1;
        iso_mask  = 1'b1;
        dom_rst_n = 1'b0;
        clk_en    = 1'b0;
        case (st_q)
            DS_ON: begin
                iso_mask  = 1'b0;
                dom_rst_n = 1'b1;
                clk_en    = 1'b1;
            end
            DS_GATED: begin
                iso_mask  = 1'b0;
                dom_rst_n = 1'b1;
            end
            DS_DN_MASK:   dom_rst_n = 1'b1;
            DS_DN_RST:    dom_rst_n = 1'b0;
            DS_DN_SW:     sw_en = 1'b0;
            DS_OFF:       sw_en = 1'b0;
            DS_UP_SW:     dom_rst_n = 1'b0;
            DS_UP_SETTLE: dom_rst_n = 1'b0;
            DS_UP_RST:    dom_rst_n = 1'b1;
            default:      sw_en = 1'b0;
        endcase
    end

    // Arrival flag for the mode controller.
    always_comb begin
        case (tgt)
            DT_ON:    at_tgt = (st_q == DS_ON);
            DT_GATED: at_tgt = (st_q == DS_GATED);
            DT_OFF:   at_tgt = (st_q == DS_OFF);
            default:  at_tgt = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Mode controller: accepts requests and wakes, selects the target mode,
// waits for every region to arrive, then publishes the mode code.
// Requests and wakes seen during a change are held for the idle cycle
// that follows it; a wake outranks a request.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [MW-1:0] req_mode,
    input  logic          wake,
    input  logic          all_done,
    output logic [MW-1:0] act_mode,
    output logic [MW-1:0] mode_stat,
    output logic          busy
);

    logic          in_seq;
    logic          req_pend;
    logic [MW-1:0] pend_mode;
    logic          wake_pend;
    logic          req_ok;
    logic [MW-1:0] req_sel;
    logic          req_hit;
    logic          wake_hit;

    // Select the request to act on in an idle cycle.
    always_comb begin
        req_ok   = req_valid && mode_legal(req_mode);
        req_sel  = req_ok ? req_mode : pend_mode;
        req_hit  = (req_ok || req_pend) && (req_sel != mode_stat);
        wake_hit = (wake || wake_pend) && is_low_power(mode_stat);
    end

    // Mode change control, hold registers and published mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_seq    <= 1'b0;
            act_mode  <= PM_RUN;
            mode_stat <= PM_RUN;
            req_pend  <= 1'b0;
            pend_mode <= PM_RUN;
            wake_pend <= 1'b0;
        end else if (!in_seq) begin
            if (wake_hit) begin
                act_mode <= PM_RUN;
                in_seq   <= 1'b1;
            end else if (req_hit) begin
                act_mode <= req_sel;
                in_seq   <= 1'b1;
            end
            req_pend  <= 1'b0;
            wake_pend <= 1'b0;
        end else begin
            if (req_ok) begin
                req_pend  <= 1'b1;
                pend_mode <= req_mode;
            end
            if (wake) wake_pend <= 1'b1;
            if (all_done) begin
                mode_stat <= act_mode;
                in_seq    <= 1'b0;
            end
        end
    end

    assign busy = in_seq;

endmodule

// File: rtl/pwr_mode_seq.sv
// Top of the power mode sequencer: one mode controller and one region
// sequencer per switchable region. The CPU clock runs only in the settled
// run modes. Assumes sw_ack follows sw_en with a finite delay.
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int SETTLE_D0 = 4,
    parameter int SETTLE_D1 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_mode,
    input  logic       wake,
    input  logic [1:0] sw_ack,
    output logic [1:0] sw_en,
    output logic [1:0] iso_mask,
    output logic [1:0] dom_rst_n,
    output logic [1:0] dom_clk_en,
    output logic       cpu_clk_en,
    output logic [2:0] mode_stat,
    output logic       busy
);

    logic [MW-1:0]   act_mode;
    logic [NDOM-1:0] dom_done;

    pwr_mode_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .wake      (wake),
        .all_done  (&dom_done),
        .act_mode  (act_mode),
        .mode_stat (mode_stat),
        .busy      (busy)
    );

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        localparam int ST = (g == 0) ? SETTLE_D0 : SETTLE_D1;
        dtgt_t tgt;
        assign tgt = dom_target(act_mode, g);
        pwr_dom_seq #(.SETTLE(ST)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .tgt       (tgt),
            .sw_ack    (sw_ack[g]),
            .sw_en     (sw_en[g]),
            .iso_mask  (iso_mask[g]),
            .dom_rst_n (dom_rst_n[g]),
            .clk_en    (dom_clk_en[g]),
            .at_tgt    (dom_done[g])
        );
    end

    assign cpu_clk_en = !busy && cpu_runs(mode_stat);

endmodule

// File: rtl/pwr_mode_seq_chk.sv
// Property checker for the power mode sequencer, bound to the top.
// Checks step ordering per region and the mode publication rule.
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sw_ack,
    input logic [1:0] sw_en,
    input logic [1:0] iso_mask,
    input logic [1:0] dom_rst_n,
    input logic [1:0] dom_clk_en,
    input logic       cpu_clk_en,
    input logic [2:0] mode_stat,
    input logic       busy
);

    for (genvar i = 0; i < 2; i++) begin : g_chk
        AST_OFF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            !sw_en[i] |-> (iso_mask[i] && !dom_rst_n[i] && !dom_clk_en[i])); // R6
        AST_CLK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
            dom_clk_en[i] |-> (!iso_mask[i] && dom_rst_n[i])); // R5
        AST_CLK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(iso_mask[i]) |-> !$past(dom_clk_en[i])); // R4
        AST_MASK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dom_rst_n[i]) |-> $past(iso_mask[i])); // R4
        AST_RST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sw_en[i]) |-> !$past(dom_rst_n[i])); // R4
        AST_ACK_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dom_rst_n[i]) |-> $past(sw_ack[i])); // R5
    end

    AST_CPU_DOM0: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> dom_clk_en[0]); // R7
    AST_STAT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_stat) |-> ($past(busy) && !busy)); // R12

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_ack     (sw_ack),
    .sw_en      (sw_en),
    .iso_mask   (iso_mask),
    .dom_rst_n  (dom_rst_n),
    .dom_clk_en (dom_clk_en),
    .cpu_clk_en (cpu_clk_en),
    .mode_stat  (mode_stat),
    .busy       (busy)
);

// File: tb/pwr_mode_seq_test.sv
// Bench for the power mode sequencer: sweeps every mode pair, every wake
// case and the collision cases; a per-cycle monitor judges step order and
// settle delay. The switch model acknowledges after ACK_L cycles.
module pwr_mode_seq_test;

    localparam int S0    = 4;
    localparam int S1    = 6;
    localparam int ACK_L = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = 3'd0;
    logic       wake = 1'b0;
    logic [1:0] sw_ack;
    logic [1:0] sw_en, iso_mask, dom_rst_n, dom_clk_en;
    logic       cpu_clk_en, busy;
    logic [2:0] mode_stat;

    int n_chk = 0;
    int n_fail = 0;
    logic mon_on = 1'b0;
    logic r13_arm = 1'b0;
    logic r13_drop = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_seq #(.SETTLE_D0(S0), .SETTLE_D1(S1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .wake(wake), .sw_ack(sw_ack), .sw_en(sw_en), .iso_mask(iso_mask),
        .dom_rst_n(dom_rst_n), .dom_clk_en(dom_clk_en), .cpu_clk_en(cpu_clk_en),
        .mode_stat(mode_stat), .busy(busy)
    );

    // Switch model: acknowledge follows the enable after ACK_L cycles.
    logic [ACK_L-1:0] p0 = '1;
    logic [ACK_L-1:0] p1 = '1;
    always @(posedge clk) begin
        p0 <= {p0[ACK_L-2:0], sw_en[0]};
        p1 <= {p1[ACK_L-2:0], sw_en[1]};
    end
    assign sw_ack = {p1[ACK_L-1], p0[ACK_L-1]};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected settled outputs of one region: {sw, mask, rst_n, clk}; 0 on, 1 stopped, 2 off.
    function automatic logic [3:0] reg_vec(input int st);
        case (st)
            0:       return 4'b1011;
            1:       return 4'b1010;
            default: return 4'b0100;
        endcase
    endfunction

    // Expected {mode, sw_en, mask, rst_n, clk_en, cpu} for a settled mode.
    function automatic logic [11:0] exp_vec(input logic [2:0] m);
        int s0, s1;
        logic [3:0] a, b;
        s0 = (m == 3'd2 || m == 3'd6) ? 1 : (m == 3'd3) ? 2 : 0;
        s1 = (m <= 3'd1) ? 0 : (m == 3'd2) ? 1 : 2;
        a = reg_vec(s0);
        b = reg_vec(s1);
        return {m, b[3], a[3], b[2], a[2], b[1], a[1], b[0], a[0], (m == 3'd0 || m == 3'd4)};
    endfunction

    function automatic logic [11:0] act_vec();
        return {mode_stat, sw_en, iso_mask, dom_rst_n, dom_clk_en, cpu_clk_en};
    endfunction

    // Per-cycle monitor of ordering, masking and settle delay.
    logic [1:0] pm, pr, ps, pc;
    int scnt [2];
    initial begin scnt[0] = 0; scnt[1] = 0; end
    always @(negedge clk) begin
        if (mon_on) begin
            for (int d = 0; d < 2; d++) begin
                int sexp;
                logic bad;
                sexp = (d == 0) ? S0 : S1;
                bad = 1'b0;
                if (!sw_en[d] && !(iso_mask[d] && !dom_rst_n[d] && !dom_clk_en[d])) begin
                    bad = 1'b1; $display("FAIL R6 region %0d open while unpowered", d);
                end
                if (dom_clk_en[d] && (iso_mask[d] || !dom_rst_n[d])) begin
                    bad = 1'b1; $display("FAIL R5 region %0d clocked while masked or in reset", d);
                end
                if (iso_mask[d] && !pm[d] && pc[d]) begin
                    bad = 1'b1; $display("FAIL R4 region %0d mask rose with clock running", d);
                end
                if (!dom_rst_n[d] && pr[d] && !pm[d]) begin
                    bad = 1'b1; $display("FAIL R4 region %0d reset before mask", d);
                end
                if (!sw_en[d] && ps[d] && pr[d]) begin
                    bad = 1'b1; $display("FAIL R4 region %0d switch opened before reset", d);
                end
                if (!iso_mask[d] && pm[d] && scnt[d] != sexp + 2) begin
                    bad = 1'b1;
                    $display("FAIL R5 region %0d settle actual=%0d expected=%0d", d, scnt[d], sexp + 2);
                end
                n_chk++;
                if (bad) n_fail++;
                if (!sw_en[d]) scnt[d] = 0;
                else if (sw_ack[d] && iso_mask[d]) scnt[d] = scnt[d] + 1;
            end
            if (r13_arm && !dom_clk_en[0]) r13_drop = 1'b1;
        end
        pm = iso_mask; pr = dom_rst_n; ps = sw_en; pc = dom_clk_en;
    end

    task automatic do_req(input logic [2:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_wake();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 400) begin @(negedge clk); n++; end
        if (n >= 400) chk("R12 change never completed", 32'(busy), 32'd0);
    endtask

    task automatic go_to(input logic [2:0] m);
        if (mode_stat != m) begin do_req(m); wait_idle(); end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", 32'(act_vec()), 32'(exp_vec(3'd0)));
        chk("R1 reset busy", 32'(busy), 32'd0);
        mon_on = 1'b1;

        // R3: spare code and same-mode request start nothing.
        do_req(3'd7);
        chk("R3 code 7 busy", 32'(busy), 32'd0);
        chk("R3 code 7 outputs", 32'(act_vec()), 32'(exp_vec(3'd0)));
        do_req(3'd0);
        chk("R3 same mode busy", 32'(busy), 32'd0);

        // R13: isolation-1 off while isolation-0 keeps its clock.
        r13_arm = 1'b1;
        do_req(3'd4);
        wait_idle();
        r13_arm = 1'b0;
        chk("R13 isolation-0 clock held", 32'(r13_drop), 32'd0);
        chk("R13 mode 4 reached", 32'(act_vec()), 32'(exp_vec(3'd4)));

        // R8: wake ignored in mode 4.
        do_wake();
        chk("R8 wake in mode 4 busy", 32'(busy), 32'd0);
        chk("R8 wake in mode 4 outputs", 32'(act_vec()), 32'(exp_vec(3'd4)));

        // R2 R7: every ordered pair of modes.
        for (int f = 0; f < 7; f++) begin
            for (int t = 0; t < 7; t++) begin
                go_to(3'(f));
                go_to(3'(t));
                chk($sformatf("R2 R7 mode %0d to %0d", f, t), 32'(act_vec()), 32'(exp_vec(3'(t))));
            end
        end

        // R8: wake from each low-power mode.
        for (int m = 1; m < 7; m++) begin
            if (m != 4) begin
                go_to(3'(m));
                do_wake();
                wait_idle();
                chk($sformatf("R8 wake from mode %0d", m), 32'(act_vec()), 32'(exp_vec(3'd0)));
            end
        end

        // R9: wake and request in the same cycle.
        go_to(3'd1);
        @(negedge clk);
        wake = 1'b1; req_valid = 1'b1; req_mode = 3'd2;
        @(negedge clk);
        wake = 1'b0; req_valid = 1'b0;
        wait_idle();
        chk("R9 wake beats request", 32'(act_vec()), 32'(exp_vec(3'd0)));
        repeat (3) @(negedge clk);
        chk("R9 request discarded", 32'(mode_stat), 32'd0);

        // R10 R12: requests held during a change, last one kept.
        go_to(3'd0);
        do_req(3'd3);
        chk("R12 mode held while busy", 32'(mode_stat), 32'd0);
        do_req(3'd1);
        do_req(3'd2);
        wait_idle();
        chk("R10 first change published", 32'(mode_stat), 32'd3);
        @(negedge clk);
        chk("R10 held request started", 32'(busy), 32'd1);
        wait_idle();
        chk("R10 last request applied", 32'(act_vec()), 32'(exp_vec(3'd2)));

        // R11: wake held during a change into a low-power mode.
        go_to(3'd0);
        do_req(3'd3);
        do_wake();
        wait_idle();
        chk("R11 DeepStop published first", 32'(mode_stat), 32'd3);
        @(negedge clk);
        wait_idle();
        chk("R11 held wake applied", 32'(act_vec()), 32'(exp_vec(3'd0)));

        // R11: held wake dropped when the reached mode runs.
        do_req(3'd4);
        do_wake();
        wait_idle();
        @(negedge clk);
        chk("R11 held wake dropped", 32'(busy), 32'd0);
        chk("R11 mode 4 kept", 32'(act_vec()), 32'(exp_vec(3'd4)));

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule